// File: doc/BRIEF.md
# Mode-Selectable Triple-Substitution Block Encryptor

This block encrypts one 128-bit block at a time. It follows the AES-128 round structure, with two changes. Each byte substitution passes the byte through the standard AES S-box three times in a row. The row rotation uses one of two offset patterns, and a mode input picks which one. The round keys come from the standard AES-128 key schedule, which the block computes on the fly as the rounds run. The block needs no precomputed key storage.

A user drives a plaintext, a key and a mode, then pulses `load_i` while the engine is idle. The engine completes one round per clock. After the tenth round it pulses `done_o` for one cycle. The ciphertext on `cipher_o` then stays unchanged until the next job completes. Inputs that arrive while a job is running have no effect on it.

Top module: `tcx_enc_core`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `done_o` is 0 and `cipher_o` is all zeros, and the engine is idle.
- R2: With mode 0, the result follows these steps:
  - Byte i of a block is bits [127-8i -: 8]. It sits at row i%4, column i/4 of the 4x4 state.
  - The engine first XORs the key into the plaintext.
  - It then runs 10 rounds, in this order within each round:
    - It substitutes every byte x by S(S(S(x))), with S the AES S-box.
    - It rotates rows 0,1,2,3 left by 2,0,3,1 byte positions.
    - In rounds 1 to 9 only, it mixes every column with {02},{03},{01},{01} over GF(2^8).
    - It XORs in the round key from the AES-128 key schedule. The first round constant is 01, and the constant doubles each round.
- R3: With mode 1, the computation is the same as R2, except that rows 0,1,2,3 rotate left by 1,3,0,2 byte positions.
- R4: `done_o` is high for exactly one cycle. It rises at the 10th rising clock edge after the edge that accepts `load_i`.
- R5: A `load_i` pulse that arrives while a job is running is ignored. The running job's result and timing are unchanged, and no extra `done_o` occurs.
- R6: `cipher_o` changes only at the edge where `done_o` rises. It holds its value between completions, whatever the inputs do.
- R7: Plaintext, key and mode are captured when `load_i` is accepted. A change of `mode_i` during a run does not affect the result.
- R8: A reset during a run aborts the job. No `done_o` follows until a new load, and `cipher_o` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start request, accepted only when idle |
| mode_i | input | 1 | Row-rotation pattern select, captured at load |
| plain_i | input | 128 | Plaintext block |
| key_i | input | 128 | Cipher key |
| cipher_o | output | 128 | Ciphertext, held between completions |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
An internal error becomes visible at the ports only when `done_o` rises, 10 cycles after the load. The ciphertext has no intermediate output, so a bad round key, a wrong rotation offset or a wrong substitution byte shows up only as a ciphertext that differs completely from the expected one. A fault in the round counter or the idle/run control shows up at once as a `done_o` pulse at the wrong time, or as a spurious or missing pulse. A fault in capturing the mode or the data at load shows up only when the inputs change during a run. For that reason the stimulus deliberately changes `mode_i` and pulses `load_i` while the engine is busy.

// File: rtl/tcx_pkg.sv
package tcx_pkg;

  typedef logic [15:0][7:0]  blk_t;
  typedef logic [255:0][7:0] lut_t;

  typedef enum logic {S_IDLE, S_RUN} fsm_e;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // byte slot in a packed block for column c, row r (byte 0 is the top byte)
  function automatic int idx(input int c, input int r);
    return 15 - (4 * c + r);
  endfunction

  // left rotation of row r for the selected mode
  function automatic int rot_amt(input logic md, input int r);
    int a;
    if (md) begin
      case (r)
        0: a = 1;
        1: a = 3;
        2: a = 0;
        default: a = 2;
      endcase
    end else begin
      case (r)
        0: a = 2;
        1: a = 0;
        2: a = 3;
        default: a = 1;
      endcase
    end
    return a;
  endfunction

  // S-box built from exp/log tables with generator 03, then the affine map
  function automatic lut_t mk_sbox();
    lut_t ex, lg, res;
    logic [7:0] p, inv, v;
    ex = '0;
    lg = '0;
    res = '0;
    p = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[8'(i)] = p;
      lg[p] = 8'(i);
      p = p ^ xt(p);
    end
    for (int x = 0; x < 256; x++) begin
      if (x == 0) inv = 8'h00;
      else inv = ex[8'((255 - int'(lg[8'(x)])) % 255)];
      for (int b = 0; b < 8; b++) begin
        v[b] = inv[b] ^ inv[(b + 4) % 8] ^ inv[(b + 5) % 8] ^
               inv[(b + 6) % 8] ^ inv[(b + 7) % 8];
      end
      res[8'(x)] = v ^ 8'h63;
    end
    return res;
  endfunction

  function automatic lut_t mk_sbox3(input lut_t s);
    lut_t res;
    for (int x = 0; x < 256; x++) res[8'(x)] = s[s[s[8'(x)]]];
    return res;
  endfunction

  localparam lut_t SBOX1 = mk_sbox();
  localparam lut_t SBOX3 = mk_sbox3(SBOX1);

endpackage

// File: rtl/tcx_sub.sv
module tcx_sub
  import tcx_pkg::*;
#(
  parameter int NBYTES = 16,
  parameter bit TRIPLE = 1'b1
) (
  input  logic [NBYTES*8-1:0] din,
  output logic [NBYTES*8-1:0] dout
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    if (TRIPLE) begin : g_tri
      assign dout[g*8 +: 8] = SBOX3[din[g*8 +: 8]];
    end else begin : g_one
      assign dout[g*8 +: 8] = SBOX1[din[g*8 +: 8]];
    end
  end

endmodule

// File: rtl/tcx_keystep.sv
module tcx_keystep
  import tcx_pkg::*;
(
  input  logic [127:0] rk_i,
  input  logic [7:0]   rcon_i,
  output logic [127:0] rk_o
);

  logic [31:0] w0, w1, w2, w3, rot, subw, tmp;
  logic [31:0] n0, n1, n2, n3;

  assign w0  = rk_i[127:96];
  assign w1  = rk_i[95:64];
  assign w2  = rk_i[63:32];
  assign w3  = rk_i[31:0];
  assign rot = {w3[23:0], w3[31:24]};

  tcx_sub #(.NBYTES(4), .TRIPLE(1'b0)) u_subw (
    .din  (rot),
    .dout (subw)
  );

  always_comb begin
    tmp = subw ^ {rcon_i, 24'h000000};
    n0  = w0 ^ tmp;
    n1  = w1 ^ n0;
    n2  = w2 ^ n1;
    n3  = w3 ^ n2;
    rk_o = {n0, n1, n2, n3};
  end

endmodule

// File: rtl/tcx_round.sv
module tcx_round
  import tcx_pkg::*;
(
  input  blk_t        st_i,
  input  logic [127:0] rk_i,
  input  logic        mode_i,
  input  logic        last_i,
  output blk_t        st_o
);

  blk_t sb, sh, mx;
  logic [7:0] a0, a1, a2, a3;

  tcx_sub #(.NBYTES(16), .TRIPLE(1'b1)) u_sub (
    .din  (st_i),
    .dout (sb)
  );

  always_comb begin
    sh = '0;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        sh[idx(c, r)] = sb[idx((c + rot_amt(mode_i, r)) % 4, r)];
      end
    end
  end

  always_comb begin
    mx = '0;
    a0 = '0; a1 = '0; a2 = '0; a3 = '0;
    for (int c = 0; c < 4; c++) begin
      a0 = sh[idx(c, 0)];
      a1 = sh[idx(c, 1)];
      a2 = sh[idx(c, 2)];
      a3 = sh[idx(c, 3)];
      mx[idx(c, 0)] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      mx[idx(c, 1)] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      mx[idx(c, 2)] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      mx[idx(c, 3)] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
  end

  assign st_o = (last_i ? sh : mx) ^ rk_i;

endmodule

// File: rtl/tcx_enc_core.sv
module tcx_enc_core
  import tcx_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         mode_i,
  input  logic [127:0] plain_i,
  input  logic [127:0] key_i,
  output logic [127:0] cipher_o,
  output logic         done_o
);

  localparam int RW = $clog2(ROUNDS + 1);

  fsm_e         fsm_q, fsm_d;
  blk_t         st_q, st_d, rnd_out;
  logic [127:0] rk_q, rk_d, rk_next;
  logic [7:0]   rcon_q, rcon_d;
  logic [RW-1:0] rnd_q, rnd_d;
  logic         mode_q;
  logic [127:0] ct_q;
  logic         done_q, done_d;
  logic         accept, run, last, st_en, ct_en;

  tcx_keystep u_key (
    .rk_i   (rk_q),
    .rcon_i (rcon_q),
    .rk_o   (rk_next)
  );

  tcx_round u_round (
    .st_i   (st_q),
    .rk_i   (rk_next),
    .mode_i (mode_q),
    .last_i (last),
    .st_o   (rnd_out)
  );

  // next-state logic
  always_comb begin
    accept = (fsm_q == S_IDLE) && load_i;
    run    = (fsm_q == S_RUN);
    last   = (rnd_q == RW'(ROUNDS));
    st_en  = accept || run;
    ct_en  = run && last;
    done_d = run && last;

    fsm_d = fsm_q;
    case (fsm_q)
      S_IDLE:  if (load_i) fsm_d = S_RUN;
      default: if (last)   fsm_d = S_IDLE;
    endcase

    st_d   = accept ? blk_t'(plain_i ^ key_i) : rnd_out;
    rk_d   = accept ? key_i : rk_next;
    rcon_d = accept ? 8'h01 : xt(rcon_q);
    rnd_d  = accept ? RW'(1) : rnd_q + RW'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= S_IDLE;
      done_q <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      rk_q   <= '0;
      rcon_q <= '0;
      rnd_q  <= '0;
    end else if (st_en) begin
      st_q   <= st_d;
      rk_q   <= rk_d;
      rcon_q <= rcon_d;
      rnd_q  <= rnd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else if (accept) mode_q <= mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ct_q <= '0;
    else if (ct_en) ct_q <= rnd_out;
  end

  assign cipher_o = ct_q;
  assign done_o   = done_q;

endmodule

// File: rtl/tcx_enc_core_chk.sv
module tcx_enc_core_chk #(
  parameter int ROUNDS = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_i,
  input logic [127:0] cipher_o,
  input logic         done_o
);

  localparam int CW = $clog2(ROUNDS + 2);

  logic          busy;
  logic [CW-1:0] cnt;

  // independent job tracker seen from the ports only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (done_o) begin
      busy <= load_i;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + CW'(1);
    end else if (load_i) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!done_o && cipher_o == '0);
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy && cnt == CW'(ROUNDS)));

  assert_no_early_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CW'(ROUNDS)) |-> !done_o);

  assert_ct_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cipher_o) |-> done_o);

endmodule

bind tcx_enc_core tcx_enc_core_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_i   (load_i),
  .cipher_o (cipher_o),
  .done_o   (done_o)
);

// File: tb/tcx_enc_core_test.sv
`timescale 1ns/1ps
module tcx_enc_core_test;

  localparam int ROUNDS = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [127:0] plain_i = '0;
  logic [127:0] key_i = '0;
  logic [127:0] cipher_o;
  logic         done_o;

  int nchk = 0;
  int nfail = 0;

  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic [7:0]   tsb [256];

  always #5 clk = ~clk;

  tcx_enc_core #(.ROUNDS(ROUNDS)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .mode_i   (mode_i),
    .plain_i  (plain_i),
    .key_i    (key_i),
    .cipher_o (cipher_o),
    .done_o   (done_o)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp, input string what);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] plain_sbox(input logic [7:0] v);
    logic [7:0] inv = 8'h00;
    if (v != 0) begin
      inv = 8'h01;
      for (int i = 0; i < 254; i++) inv = gm(inv, v);
    end
    return inv ^ rl(inv, 1) ^ rl(inv, 2) ^ rl(inv, 3) ^ rl(inv, 4) ^ 8'h63;
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] key,
                                           input logic md);
    logic [7:0] s[16];
    logic [7:0] t[16];
    logic [7:0] k[16];
    logic [7:0] tmp[4];
    logic [7:0] a0, a1, a2, a3, rc;
    int off1[4] = '{1, 3, 0, 2};
    int off0[4] = '{2, 0, 3, 1};
    logic [127:0] res;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) begin
      k[i] = key[127-8*i -: 8];
      s[i] = pt[127-8*i -: 8] ^ k[i];
    end
    for (int rnd = 1; rnd <= ROUNDS; rnd++) begin
      for (int i = 0; i < 16; i++) s[i] = tsb[tsb[tsb[s[i]]]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          t[4*c+r] = s[4*((c + (md ? off1[r] : off0[r])) % 4) + r];
      for (int c = 0; c < 4; c++) begin
        a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
        if (rnd < ROUNDS) begin
          s[4*c]   = gm(a0, 2) ^ gm(a1, 3) ^ a2 ^ a3;
          s[4*c+1] = a0 ^ gm(a1, 2) ^ gm(a2, 3) ^ a3;
          s[4*c+2] = a0 ^ a1 ^ gm(a2, 2) ^ gm(a3, 3);
          s[4*c+3] = gm(a0, 3) ^ a1 ^ a2 ^ gm(a3, 2);
        end else begin
          s[4*c] = a0; s[4*c+1] = a1; s[4*c+2] = a2; s[4*c+3] = a3;
        end
      end
      tmp[0] = tsb[k[13]] ^ rc;
      tmp[1] = tsb[k[14]];
      tmp[2] = tsb[k[15]];
      tmp[3] = tsb[k[12]];
      for (int i = 0; i < 4; i++) k[i] ^= tmp[i];
      for (int i = 4; i < 16; i++) k[i] ^= k[i-4];
      rc = gm(rc, 2);
      for (int i = 0; i < 16; i++) s[i] ^= k[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", cipher_o, '0, "unexpected completion");
      end else begin
        logic [127:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(cipher_o === e, tg, cipher_o, e, "ciphertext");
      end
    end
  end

  // ---------------- driver ----------------
  task automatic run_job(input logic [127:0] pt, input logic [127:0] key, input logic md,
                         input string tg, input bit poke, input bit flip);
    logic [127:0] e;
    int lat;
    e = ref_enc(pt, key, md);
    exp_q.push_back(e);
    tag_q.push_back(tg);
    plain_i = pt; key_i = key; mode_i = md; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40) begin
      if (poke && (lat == 4 || lat == 5)) begin
        load_i = 1'b1; plain_i = ~pt; key_i = pt ^ 128'h5a;
      end else begin
        load_i = 1'b0;
      end
      if (flip && lat >= 2) mode_i = ~md;
      @(negedge clk);
      lat++;
    end
    load_i = 1'b0;
    // load accepted at first edge, done rises on the 10th edge after it
    check(lat == ROUNDS + 1, "R4", 128'(lat), 128'(ROUNDS + 1), "done latency");
    plain_i = ~plain_i; key_i = ~key_i; mode_i = ~mode_i;
    @(negedge clk);
    check(done_o == 1'b0, "R4", 128'(done_o), 128'd0, "done width");
    repeat (3) @(negedge clk);
    check(cipher_o === e, "R6", cipher_o, e, "ciphertext held");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R4", '0, '0, "watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) tsb[i] = plain_sbox(8'(i));

    // R1: reset state
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1", 128'(done_o), 128'd0, "done in reset");
    check(cipher_o == '0, "R1", cipher_o, '0, "cipher in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0 && cipher_o == '0, "R1", cipher_o, '0, "idle after reset");

    run_job('0, '0, 1'b0, "R2", 1'b0, 1'b0);
    run_job('0, '0, 1'b1, "R3", 1'b0, 1'b0);
    run_job(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
            1'b0, "R2", 1'b0, 1'b0);
    run_job(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
            1'b1, "R3", 1'b0, 1'b0);
    run_job('1, '1, 1'b1, "R5", 1'b1, 1'b0);
    run_job(128'h0123456789abcdeffedcba9876543210, 128'h2b7e151628aed2a6abf7158809cf4f3c,
            1'b0, "R7", 1'b0, 1'b1);
    run_job(128'h0123456789abcdeffedcba9876543210, 128'h2b7e151628aed2a6abf7158809cf4f3c,
            1'b1, "R7", 1'b1, 1'b1);
    for (int j = 0; j < 4; j++) begin
      logic [127:0] p, k;
      p = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      run_job(p, k, j[0], j[0] ? "R3" : "R2", 1'b0, 1'b0);
    end

    // R8: reset during a run aborts the job
    plain_i = 128'hdeadbeef; key_i = 128'h1234; mode_i = 1'b0; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(done_o == 1'b0 && cipher_o == '0, "R8", cipher_o, '0, "abort clears");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (15) @(negedge clk);
    check(done_o == 1'b0 && cipher_o == '0, "R8", cipher_o, '0, "no result after abort");

    run_job(128'h80000000000000000000000000000001, 128'h1, 1'b1, "R3", 1'b0, 1'b0);

    check(exp_q.size() == 0, "R5", 128'(exp_q.size()), 128'd0, "scoreboard drained");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule